// File: doc/BRIEF.md
# Configuration Cycle Decoder and Translator

This block sits on the upstream port of a PCI-to-PCI style bridge. It looks at each configuration cycle that reaches the port and picks one of three outcomes. It can claim the cycle for the bridge's own internal functions. It can rewrite a Type 1 cycle as a Type 0 cycle for the bus directly below the bridge. Or it can leave the cycle as it is. In the rewritten address, the target device is selected by a single set bit in the upper half of the address, in the usual IDSEL style.

Each input cycle is marked by a valid strobe and comes with a command code, a 32-bit address and a flag that says which side of the bridge the cycle arrived from. One clock later the block returns a registered result: a valid strobe, a claim flag, a translate flag and the outgoing address. The number of the bus directly below the bridge is held in a small register that has its own write port.

Top module: `cfgx_decoder`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_claim` and `out_xlate` are low and `out_addr` is zero. The secondary bus register resets to 0, so a matching Type 1 cycle for bus 0 is translated right after reset.
- R2: A cycle presented with `in_valid` high on a clock edge produces `out_valid` high after that edge. With `in_valid` low, `out_valid`, `out_claim` and `out_xlate` are low after the edge.
- R3: Only command codes 4'hA (configuration read) and 4'hB (configuration write) can be claimed or translated. Every other code gives both flags low.
- R4: A cycle is claimed (`out_claim` high) when all of these hold: it is a configuration command, `in_from_down` is 0, address bits [1:0] are 2'b00, and the device field in bits [15:11] is between 27 and 31 inclusive.
- R5: A cycle with `in_from_down` = 1 is never claimed and never translated.
- R6: A cycle is translated (`out_xlate` high) when all of these hold: it is a configuration command, `in_from_down` is 0, address bits [1:0] are 2'b01, and bits [23:16] equal the secondary bus register.
- R7: In a translated address, device n (bits [15:11], n from 0 to 15) sets bit 16+n and no other bit in [31:16]. Device numbers 16 to 31 leave [31:16] all zero.
- R8: In a translated address, bits [10:2] (function in [10:8], register in [7:2]) are copied unchanged, and bits [15:11] and [1:0] are zero.
- R9: A valid cycle that is not translated comes out with `out_addr` equal to `in_addr`. This covers claimed cycles and Type 1 cycles whose bus does not match.
- R10: `out_claim` and `out_xlate` are never high together.
- R11: `bus_we` loads `bus_wdata` into the secondary bus register at the clock edge. A cycle sampled on that same edge is compared against the value held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A cycle is presented this clock |
| in_cmd | input | 4 | Bus command code |
| in_addr | input | 32 | Configuration address |
| in_from_down | input | 1 | 1 = the cycle arrived from the downstream side |
| bus_we | input | 1 | Load strobe for the secondary bus register |
| bus_wdata | input | 8 | New secondary bus number |
| out_valid | output | 1 | A result is present |
| out_claim | output | 1 | Cycle claimed for the internal functions |
| out_xlate | output | 1 | Cycle translated from Type 1 to Type 0 |
| out_addr | output | 32 | Translated or passed-through address |

## Verification
Every result is due exactly one clock after the edge that samples its cycle. A bus register load takes effect at that same edge, but it only affects cycles sampled on later edges.

The bench drives inputs on the falling edge. On each rising edge, a behavioural model takes the same inputs, computes the expected result and then applies any bus register load. The design's outputs are compared with that expected result on the next falling edge.

Directed cycles cover the edges of the claim band, the format bits, non-configuration commands, downstream cycles, device numbers at and beyond 15, and a register load on the same edge as a cycle. A long biased random run follows.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int CMD_BITS = 4;

   typedef enum logic [CMD_BITS-1:0] {
      CMD_CFG_RD = 4'hA,
      CMD_CFG_WR = 4'hB
   } cfgx_cmd_e;

   typedef enum logic [1:0] {
      FMT_LOCAL = 2'b00,
      FMT_ROUTE = 2'b01
   } cfgx_fmt_e;

   typedef struct packed {
      logic claim;
      logic xlate;
   } cfgx_verdict_t;

endpackage

// File: rtl/cfgx_busreg.sv
module cfgx_busreg #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/cfgx_classify.sv
module cfgx_classify
   import cfgx_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int DEV_LO = 27,
   parameter int DEV_HI = 31
) (
   input  logic [CMD_BITS-1:0] cmd,
   input  logic [1:0]          fmt,
   input  logic [DEV_W-1:0]    dev,
   input  logic [BUS_W-1:0]    bus,
   input  logic                from_down,
   input  logic [BUS_W-1:0]    secbus,
   output cfgx_verdict_t       verdict
);

   localparam int DEV_TOP = (1 << DEV_W) - 1;

   logic is_cfg;
   logic in_band;

   assign is_cfg = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);

   // The upper bound check is dropped when the band reaches the top code.
   generate
      if (DEV_HI == DEV_TOP) begin : g_band_open
         assign in_band = (dev >= DEV_W'(DEV_LO));
      end else begin : g_band_closed
         assign in_band = (dev >= DEV_W'(DEV_LO)) && (dev <= DEV_W'(DEV_HI));
      end
   endgenerate

   always_comb begin
      verdict.claim = is_cfg && !from_down && (fmt == FMT_LOCAL) && in_band;
      verdict.xlate = is_cfg && !from_down && (fmt == FMT_ROUTE) && (bus == secbus);
   end

endmodule

// File: rtl/cfgx_idsel.sv
module cfgx_idsel #(
   parameter int ADDR_W    = 32,
   parameter int DEV_W     = 5,
   parameter int SEL_BASE  = 16,
   parameter int SEL_COUNT = 16,
   parameter int KEEP_LSB  = 2,
   parameter int KEEP_MSB  = 10
) (
   input  logic [DEV_W-1:0]           dev,
   input  logic [KEEP_MSB:KEEP_LSB]   keep,
   output logic [ADDR_W-1:0]          xaddr
);

   generate
      for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
         if (g >= SEL_BASE && g < SEL_BASE + SEL_COUNT) begin : g_sel
            assign xaddr[g] = (dev == DEV_W'(g - SEL_BASE));
         end else if (g >= KEEP_LSB && g <= KEEP_MSB) begin : g_keep
            assign xaddr[g] = keep[g];
         end else begin : g_zero
            assign xaddr[g] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/cfgx_decoder.sv
module cfgx_decoder
   import cfgx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BUS_W     = 8,
   parameter int CMD_W     = 4,
   parameter int DEV_LO    = 27,
   parameter int DEV_HI    = 31,
   parameter int SEL_BASE  = 16,
   parameter int SEL_COUNT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CMD_W-1:0]  in_cmd,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_from_down,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic              out_valid,
   output logic              out_claim,
   output logic              out_xlate,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int DEV_W    = 5;
   localparam int DEV_LSB  = 11;
   localparam int DEV_MSB  = DEV_LSB + DEV_W - 1;
   localparam int BUS_LSB  = 16;
   localparam int BUS_MSB  = BUS_LSB + BUS_W - 1;
   localparam int KEEP_LSB = 2;
   localparam int KEEP_MSB = DEV_LSB - 1;

   generate
      if (ADDR_W != 32)                          begin : g_chk_addr  $error("ADDR_W must be 32"); end
      if (CMD_W != CMD_BITS)                     begin : g_chk_cmd   $error("CMD_W must match package"); end
      if (BUS_MSB >= ADDR_W)                     begin : g_chk_bus   $error("bus field exceeds address"); end
      if (SEL_BASE + SEL_COUNT > ADDR_W)         begin : g_chk_sel   $error("select field exceeds address"); end
      if (SEL_BASE <= DEV_MSB)                   begin : g_chk_ovl   $error("select field overlaps device field"); end
      if (SEL_COUNT > (1 << DEV_W))              begin : g_chk_cnt   $error("more selects than device codes"); end
      if (DEV_LO > DEV_HI || DEV_HI >= (1 << DEV_W)) begin : g_chk_band $error("bad claim band"); end
   endgenerate

   logic [BUS_W-1:0]  sec_bus;
   cfgx_verdict_t     verdict;
   logic [ADDR_W-1:0] xaddr;

   cfgx_busreg #(.BUS_W(BUS_W)) u_busreg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .wdata (bus_wdata),
      .q     (sec_bus)
   );

   cfgx_classify #(
      .BUS_W  (BUS_W),
      .DEV_W  (DEV_W),
      .DEV_LO (DEV_LO),
      .DEV_HI (DEV_HI)
   ) u_classify (
      .cmd       (in_cmd),
      .fmt       (in_addr[1:0]),
      .dev       (in_addr[DEV_MSB:DEV_LSB]),
      .bus       (in_addr[BUS_MSB:BUS_LSB]),
      .from_down (in_from_down),
      .secbus    (sec_bus),
      .verdict   (verdict)
   );

   cfgx_idsel #(
      .ADDR_W    (ADDR_W),
      .DEV_W     (DEV_W),
      .SEL_BASE  (SEL_BASE),
      .SEL_COUNT (SEL_COUNT),
      .KEEP_LSB  (KEEP_LSB),
      .KEEP_MSB  (KEEP_MSB)
   ) u_idsel (
      .dev   (in_addr[DEV_MSB:DEV_LSB]),
      .keep  (in_addr[KEEP_MSB:KEEP_LSB]),
      .xaddr (xaddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_claim <= 1'b0;
         out_xlate <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         out_claim <= in_valid && verdict.claim;
         out_xlate <= in_valid && verdict.xlate;
         if (in_valid) out_addr <= verdict.xlate ? xaddr : in_addr;
      end
   end

   // R2: one result per cycle, one clock later
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_claim && !out_xlate));
   // R3: other commands are ignored
   p_cmd_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cmd != CMD_CFG_RD && in_cmd != CMD_CFG_WR) |=> (!out_claim && !out_xlate));
   // R5: downstream cycles are refused
   p_down_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_from_down) |=> (!out_claim && !out_xlate));
   // R7: at most one select bit
   p_idsel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_xlate |-> $onehot0(out_addr[SEL_BASE +: SEL_COUNT]));
   // R8: cleared fields of a translated address
   p_fields_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_xlate |-> (out_addr[KEEP_LSB-1:0] == '0 && out_addr[DEV_MSB:DEV_LSB] == '0));
   // R9: untranslated addresses pass unchanged
   p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_xlate) |-> (out_addr == $past(in_addr)));
   // R10: outcomes are exclusive
   p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_claim && out_xlate));
   // R11: bus register load
   p_busreg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> (sec_bus == $past(bus_wdata)));

endmodule

// File: tb/test_cfgx_decoder.sv
module test_cfgx_decoder;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_cmd = '0;
   logic [31:0] in_addr = '0;
   logic        in_from_down = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        out_valid, out_claim, out_xlate;
   logic [31:0] out_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit run_chk  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgx_decoder i_cfgx_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd),
      .in_addr(in_addr), .in_from_down(in_from_down), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .out_valid(out_valid), .out_claim(out_claim),
      .out_xlate(out_xlate), .out_addr(out_addr)
   );

   // behavioural reference model
   int          m_bus;
   bit          e_valid, e_claim, e_xlate;
   logic [31:0] e_addr;
   string       e_tag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_bus = 0; e_valid = 0; e_claim = 0; e_xlate = 0; e_addr = '0; e_tag = "R1";
      end else begin
         int  dev;
         bit  cfg;
         dev = int'(in_addr[15:11]);
         cfg = (in_cmd == 4'hA) || (in_cmd == 4'hB);
         e_valid = in_valid; e_claim = 0; e_xlate = 0;
         if (in_valid) begin
            if (cfg && !in_from_down && in_addr[1:0] == 2'b00 && dev >= 27) e_claim = 1;
            if (cfg && !in_from_down && in_addr[1:0] == 2'b01 && int'(in_addr[23:16]) == m_bus) e_xlate = 1;
            if (e_xlate) begin
               e_addr = in_addr & 32'h0000_07FC;
               if (dev < 16) e_addr = e_addr | (32'h1 << (16 + dev));
            end else begin
               e_addr = in_addr;
            end
            if (bus_we)            e_tag = "R11";
            else if (in_from_down) e_tag = "R5";
            else if (!cfg)         e_tag = "R3";
            else if (e_claim)      e_tag = "R4";
            else if (e_xlate)      e_tag = (dev < 16) ? "R6 R7" : "R6 R8";
            else                   e_tag = "R9";
         end else begin
            e_tag = "R2";
         end
         if (bus_we) m_bus = int'(bus_wdata);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual {v,c,x,addr}=%h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         chk(out_valid == e_valid && out_claim == e_claim && out_xlate == e_xlate &&
             (!e_valid || out_addr == e_addr), e_tag,
             {out_valid, out_claim, out_xlate, out_addr}, {e_valid, e_claim, e_xlate, e_addr});
         chk(!(out_claim && out_xlate), "R10",
             {out_valid, out_claim, out_xlate, out_addr}, {e_valid, e_claim, e_xlate, e_addr});
      end
   end

   function automatic logic [31:0] t1(input int bus, input int dev, input int fn, input int rg);
      return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b01};
   endfunction

   function automatic logic [31:0] t0(input int dev, input int fn, input int rg);
      return {16'hC3A5, 5'(dev), 3'(fn), 6'(rg), 2'b00};
   endfunction

   task automatic cyc(input bit v, input logic [3:0] cmd, input logic [31:0] a,
                      input bit down, input bit we, input logic [7:0] wd);
      @(negedge clk);
      in_valid = v; in_cmd = cmd; in_addr = a; in_from_down = down;
      bus_we = we; bus_wdata = wd;
   endtask

   task automatic idle();
      cyc(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R1: outputs held at zero during reset
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_claim && !out_xlate && out_addr == 32'h0, "R1",
          {out_valid, out_claim, out_xlate, out_addr}, 35'h0);
      rst_n = 1'b1;
      run_chk = 1'b1;

      // R1/R6: bus register is 0 after reset
      cyc(1, 4'hA, t1(0, 3, 2, 5), 0, 0, 0);
      // R4: claim band edges
      cyc(1, 4'hA, t0(27, 1, 9), 0, 0, 0);
      cyc(1, 4'hB, t0(31, 7, 63), 0, 0, 0);
      cyc(1, 4'hA, t0(26, 0, 4), 0, 0, 0);
      cyc(1, 4'hA, t0(29, 0, 4) | 32'h2, 0, 0, 0);
      cyc(1, 4'hA, t0(29, 0, 4) | 32'h3, 0, 0, 0);
      // R3: other commands
      cyc(1, 4'h6, t0(28, 0, 1), 0, 0, 0);
      cyc(1, 4'h7, t1(0, 1, 0, 1), 0, 0, 0);
      // R5: downstream side
      cyc(1, 4'hA, t0(30, 0, 1), 1, 0, 0);
      cyc(1, 4'hB, t1(0, 1, 0, 1), 1, 0, 0);
      idle();
      // R11: load bus 5 with a cycle for bus 5 on the same edge (old value 0 used)
      cyc(1, 4'hA, t1(5, 2, 0, 0), 0, 1, 8'd5);
      cyc(1, 4'hA, t1(5, 2, 0, 0), 0, 0, 0);
      // R7/R8: every device number
      for (int d = 0; d < 32; d++) cyc(1, (d % 2) ? 4'hB : 4'hA, t1(5, d, d % 8, 63 - d), 0, 0, 0);
      // R9: bus mismatch passes unchanged
      cyc(1, 4'hA, t1(4, 2, 1, 1), 0, 0, 0);
      cyc(1, 4'hA, t1(6, 15, 3, 8), 0, 0, 0);
      idle();

      // biased random run
      for (int i = 0; i < 4000; i++) begin
         bit          v, dn, we;
         logic [3:0]  cmd;
         logic [31:0] a;
         v   = ($urandom % 10) < 8;
         cmd = (($urandom % 10) < 7) ? (4'hA + 4'($urandom % 2)) : 4'($urandom);
         a   = $urandom;
         a[23:16] = (($urandom % 2) == 1) ? 8'(m_bus) : 8'($urandom % 8);
         if (($urandom % 3) == 0) a[15:11] = 5'(27 + $urandom % 5);
         a[1:0] = (($urandom % 5) == 0) ? 2'($urandom) : 2'($urandom % 2);
         dn  = ($urandom % 5) == 0;
         we  = ($urandom % 20) == 0;
         cyc(v, cmd, a, dn, we, 8'($urandom % 8));
      end
      idle();
      idle();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule